// File: doc/BRIEF.md
# Converter Sample Feeder

This block is the digital front end of a single-channel 10-bit converter. A small register write port takes a control word, a sample word that converts at once, and a sample word that waits in a one-entry holding buffer. Each conversion start loads a new 10-bit code onto the code output. A conversion-busy timer then runs for a fixed number of cycles.

When event pacing is enabled, a start pulse from an external timer moves the held word into the active code and starts a conversion. Samples therefore leave at the rate of the pulse train, and software only has to keep the buffer filled. The block raises a buffer-drained pulse so that the buffer can be refilled. It keeps sticky flags for a drained buffer, for a start pulse that found the buffer empty, and for a sample write made during a busy conversion.

Control and direct sample writes pass through a two-stage synchronisation delay before they reach the converter core. This delay is modelled in a single clock domain.

Top module: `dac_front`

## Requirements
- R1: After reset the code output is 0, the status flags are 0, the buffer is empty, and conv_busy, sync_busy, out_ext and out_int are all low.
- R2: Address 0 is the control word. Bit 0 selects left adjustment, bit 1 enables start-on-event, bit 2 enables the buffer-drained pulse, and bits 4:3 select the output route: 1 external, 2 internal, 0 or 3 none. out_ext and out_int are never high together.
- R3: A write to address 0 or 1 is applied to the core exactly two cycles after the capturing edge. sync_busy is high for those two cycles.
- R4: A write to address 1 loads the code and starts a conversion when it is applied. With right adjustment the code is bits 9:0 of the word; with left adjustment it is bits 15:6.
- R5: Each conversion start holds conv_busy high for CONV_CYCLES cycles.
- R6: A write to address 2 fills the buffer and clears status bit 0. When start-on-event is disabled, evt_start has no effect.
- R7: With start-on-event enabled and the buffer full, evt_start copies the buffer word (adjusted as in R4) to the code, starts a conversion, empties the buffer and sets status bit 0.
- R8: With the buffer-drained pulse enabled, evt_empty is high for exactly the one cycle after the start pulse that drains the buffer.
- R9: With start-on-event enabled and the buffer empty, evt_start sets status bit 1 (underrun), leaves the code unchanged and starts no conversion.
- R10: A write to address 1 captured while conv_busy is high sets status bit 2 (collision), and the write is still applied.
- R11: Status flags are sticky. A write to address 3 clears each flag whose matching data bit is 1 and leaves the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 direct sample, 2 buffer, 3 status clear |
| wr_data | input | 16 | Write data |
| evt_start | input | 1 | Start-conversion event pulse |
| code | output | 10 | Active converter code |
| conv_busy | output | 1 | Conversion in progress |
| sync_busy | output | 1 | Control or sample write still synchronising |
| out_ext | output | 1 | External output route enabled |
| out_int | output | 1 | Internal output route enabled |
| evt_empty | output | 1 | Buffer-drained event pulse |
| status | output | 3 | Sticky flags: 0 drained, 1 underrun, 2 collision |

## Verification
The underrun case is the hardest to reach from the ports. It needs event pacing to have passed through synchronisation and taken effect, and it needs one start pulse to drain a full buffer before a second pulse arrives with no refill in between. The bench fills the buffer, waits until the control word has been applied, and fires two pulses. It then checks that the code kept the drained value and that conv_busy did not restart. The collision case is reached by issuing a direct write inside the busy window of the previous write.

// File: rtl/dac_front.sv
module dac_front #(
  parameter int DW = 16,
  parameter int CW = 10,
  parameter int CONV_CYCLES = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          evt_start,
  output logic [CW-1:0] code,
  output logic          conv_busy,
  output logic          sync_busy,
  output logic          out_ext,
  output logic          out_int,
  output logic          evt_empty,
  output logic [2:0]    status
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int SH = DW - CW;

  logic          p1_v, p2_v, p1_a, p2_a;
  logic [DW-1:0] p1_d, p2_d, buf_q;
  logic          buf_full, left_adj, ev_en, emp_en;
  logic [1:0]    route;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CW-1:0] adj(input logic [DW-1:0] d, input logic left);
    logic [DW-1:0] s;
    s = d >> SH;
    return left ? s[CW-1:0] : d[CW-1:0];
  endfunction

  wire buf_wr   = wr_en && wr_addr == 2'd2;
  wire data_wr  = wr_en && wr_addr == 2'd1;
  wire clr      = wr_en && wr_addr == 2'd3;
  wire ev_take  = evt_start && ev_en && buf_full;
  wire ev_under = evt_start && ev_en && !buf_full;
  wire app_ctrl = p2_v && !p2_a;
  wire app_data = p2_v && p2_a;

  assign sync_busy = p1_v | p2_v;
  assign conv_busy = cnt != '0;
  assign out_ext   = route == 2'd1;
  assign out_int   = route == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= 1'b0; p2_a <= 1'b0;
      p1_d <= '0; p2_d <= '0;
    end else begin
      p1_v <= wr_en && !wr_addr[1];
      p1_a <= wr_addr[0];
      p1_d <= wr_data;
      p2_v <= p1_v;
      p2_a <= p1_a;
      p2_d <= p1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_adj <= 1'b0; ev_en <= 1'b0; emp_en <= 1'b0; route <= 2'd0;
    end else if (app_ctrl) begin
      left_adj <= p2_d[0];
      ev_en    <= p2_d[1];
      emp_en   <= p2_d[2];
      route    <= p2_d[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0; cnt <= '0; buf_q <= '0; buf_full <= 1'b0;
      evt_empty <= 1'b0; status <= '0;
    end else begin
      if (ev_take)       code <= adj(buf_q, left_adj);
      else if (app_data) code <= adj(p2_d, left_adj);

      if (ev_take || app_data) cnt <= CNT_W'(CONV_CYCLES);
      else if (cnt != '0)      cnt <= cnt - 1'b1;

      if (buf_wr) begin
        buf_q    <= wr_data;
        buf_full <= 1'b1;
      end else if (ev_take) buf_full <= 1'b0;

      evt_empty <= ev_take && !buf_wr && emp_en;

      if (buf_wr)                 status[0] <= 1'b0;
      else if (ev_take)           status[0] <= 1'b1;
      else if (clr && wr_data[0]) status[0] <= 1'b0;

      if (ev_under)               status[1] <= 1'b1;
      else if (clr && wr_data[1]) status[1] <= 1'b0;

      if (data_wr && conv_busy)   status[2] <= 1'b1;
      else if (clr && wr_data[2]) status[2] <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [15:0] wr_data,
  input logic       conv_busy,
  input logic       sync_busy,
  input logic       out_ext,
  input logic       out_int,
  input logic       evt_empty,
  input logic [2:0] status
);
  // R2
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(out_ext && out_int));
  // R3
  sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[1]) |=> sync_busy);
  // R8
  empty_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_empty |-> status[0]);
  // R7
  empty_pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_empty |-> conv_busy);
  // R11
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> status[1]);
endmodule

bind dac_front dac_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .conv_busy(conv_busy), .sync_busy(sync_busy), .out_ext(out_ext), .out_int(out_int),
  .evt_empty(evt_empty), .status(status)
);

// File: tb/sim_dac_front.sv
module sim_dac_front;
  localparam int CONV = 6;
  logic clk = 0, rst_n = 0, wr_en = 0, evt_start = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [9:0] code;
  logic conv_busy, sync_busy, out_ext, out_int, evt_empty;
  logic [2:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dac_front #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_start(evt_start), .code(code), .conv_busy(conv_busy), .sync_busy(sync_busy),
    .out_ext(out_ext), .out_int(out_int), .evt_empty(evt_empty), .status(status));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    evt_start = 1;
    @(posedge clk); @(negedge clk);
    evt_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 code", 16'(code), 0);
    chk("R1 status", 16'(status), 0);
    chk("R1 flags", {11'd0, conv_busy, sync_busy, out_ext, out_int, evt_empty}, 0);
  endtask

  task automatic t_ctrl_sync();
    wr(2'd0, 16'h0008);
    chk("R3 sync_busy 1", 16'(sync_busy), 1);
    chk("R3 not applied", 16'(out_ext), 0);
    settle(1);
    chk("R3 sync_busy 2", 16'(sync_busy), 1);
    chk("R3 not yet", 16'(out_ext), 0);
    settle(1);
    chk("R2 ext route", {out_ext, out_int}, 2'b10);
    chk("R3 sync done", 16'(sync_busy), 0);
  endtask

  task automatic t_direct();
    int busy_n = 0;
    wr(2'd1, 16'h02A5);
    settle(1);
    chk("R4 code before apply", 16'(code), 0);
    settle(1);
    chk("R4 right adjust", 16'(code), 16'h02A5);
    for (int i = 0; i < CONV + 3; i++) begin
      if (conv_busy) busy_n++;
      settle(1);
    end
    chk("R5 busy length", 16'(busy_n), CONV);
  endtask

  task automatic t_left();
    wr(2'd0, 16'h0011);
    settle(2);
    chk("R2 int route", {out_ext, out_int}, 2'b01);
    wr(2'd1, 16'hABC0);
    settle(2);
    chk("R4 left adjust", 16'(code), 16'h02AF);
    settle(CONV + 1);
  endtask

  task automatic t_event_off();
    wr(2'd0, 16'h0000);
    settle(2);
    wr(2'd2, 16'h0123);
    pulse();
    chk("R6 event ignored code", 16'(code), 16'h02AF);
    chk("R6 event ignored status", 16'(status), 0);
    chk("R6 no busy", 16'(conv_busy), 0);
  endtask

  task automatic t_event_on();
    wr(2'd0, 16'h0006);
    settle(2);
    pulse();
    chk("R7 code from buffer", 16'(code), 16'h0123);
    chk("R7 drained flag", 16'(status), 16'h0001);
    chk("R7 busy", 16'(conv_busy), 1);
    chk("R8 pulse", 16'(evt_empty), 1);
    settle(1);
    chk("R8 pulse one cycle", 16'(evt_empty), 0);
    settle(CONV);
    pulse();
    chk("R9 underrun flag", 16'(status), 16'h0003);
    chk("R9 code kept", 16'(code), 16'h0123);
    chk("R9 no start", 16'(conv_busy), 0);
    chk("R9 no pulse", 16'(evt_empty), 0);
  endtask

  task automatic t_clear();
    wr(2'd3, 16'h0002);
    chk("R11 clear underrun only", 16'(status), 16'h0001);
    wr(2'd2, 16'h0155);
    chk("R6 buffer write clears drained", 16'(status), 0);
    wr(2'd0, 16'h0002);
    settle(2);
    pulse();
    chk("R8 no pulse when disabled", 16'(evt_empty), 0);
    chk("R7 code second", 16'(code), 16'h0155);
    wr(2'd3, 16'h0001);
    chk("R11 clear drained", 16'(status), 0);
    settle(CONV);
  endtask

  task automatic t_collide();
    wr(2'd1, 16'h0011);
    settle(2);
    wr(2'd1, 16'h0022);
    chk("R10 collision flag", 16'(status), 16'h0004);
    settle(2);
    chk("R10 write still applied", 16'(code), 16'h0022);
    wr(2'd3, 16'h0007);
    chk("R11 clear all", 16'(status), 0);
  endtask

  initial begin
    fork
      begin
        settle(2);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctrl_sync();
        t_direct();
        t_left();
        t_event_off();
        t_event_on();
        t_clear();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule